// File: doc/BRIEF.md
# Shared 2D Configuration Slot Allocator

A multi-channel DMA controller keeps a small pool of two-dimensional transfer parameter sets, and all channels share it. Each set holds a row size, a row count and a row stride. Before a 2D transfer starts, a channel asks this allocator for a set. The allocator can hand out a set that already holds the same three values, so several channels use one set through a usage count. It can also hand out a set that no channel is using, or it answers busy. When the channel's transfer ends, it releases the set and the usage count drops.

Requests are level signals, one per channel, and each channel presents its own parameters. A fixed-priority arbiter picks one requester per cycle, so the slot check and the slot update happen as one step. A one-cycle grant or busy pulse answers the request on the cycle after it was taken. The block keeps, for each channel, whether it holds a slot and which slot it holds. The stored parameters and the usage counts are outputs, so the address generators can read them.

Top module: `slot2d_alloc`

## Requirements
- R1: After reset every usage count is zero, no channel holds a slot, and `gnt_o` and `busy_o` are all zero.
- R2: A slot is eligible when its usage count is zero or when its stored size, count and stride all equal the request. The eligible slot with the lowest index is granted, and `gnt_sel_o` gives that index (0 for slot A, 1 for slot B).
- R3: A grant writes the request into the slot and increments the slot's usage count. Slot s is `slot_cfg_o[s*48 +: 48]`, packed as size [47:32], count [31:16], stride [15:0]. The request of channel c is `req_cfg_i[c*48 +: 48]` with the same packing. The usage count of slot s is `slot_cnt_o[s*5 +: 5]`.
- R4: When no slot is eligible, the channel gets a one-cycle `busy_o` pulse, and no slot parameter or usage count changes.
- R5: On a grant, `ch_en_o[c]` is set and `ch_slot_o[c]` holds the granted slot index.
- R6: When a holding channel pulses `rel_i[c]`, its flag clears and its slot's count drops by one. When several channels release the same slot in one cycle, the count drops by that number.
- R7: A release from a channel that holds no slot has no effect. A usage count never goes below zero.
- R8: A request from a channel whose `cyclic_i` bit is high is answered busy.
- R9: A request from a channel that already holds a slot is answered busy and changes nothing.
- R10: Among simultaneous requests, the lowest channel number is served first, and only one request is served per cycle. The response pulse appears one clock after the request is taken. A channel that got a response in the previous cycle is not served again in that cycle, and the other requesters wait.
- R11: A grant and a release on the same slot in the same cycle change its count by the net amount. Eligibility uses the count from before that cycle's releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Slot request level, one bit per channel |
| req_cfg_i | input | 768 | Per-channel size, count and stride, 48 bits per channel |
| cyclic_i | input | 16 | Channel is running a cyclic transfer |
| rel_i | input | 16 | Release pulse, one bit per channel |
| gnt_o | output | 16 | One-cycle grant pulse for the served channel |
| busy_o | output | 16 | One-cycle refusal pulse for the served channel |
| gnt_sel_o | output | 1 | Slot index of the latest grant |
| ch_en_o | output | 16 | Channel holds a slot |
| ch_slot_o | output | 16 | Slot index held by each channel |
| slot_cfg_o | output | 96 | Stored parameters of each slot |
| slot_cnt_o | output | 10 | Usage count of each slot, 5 bits per slot |

## Verification
Some properties are checked on every cycle:
- At most one response is given per cycle, and a response only ever goes to a channel that was requesting.
- A granted channel records the same slot index that `gnt_sel_o` reports.
- No channel that was cyclic is granted.
- A refusal leaves the slots unchanged.
- The sum of the usage counts always equals the number of holding channels, which also rules out leaked or lost counts.

Other behaviour can only be shown by the bench's scenarios:
- A second channel shares a slot when its parameters match, and a mismatch in the stride alone is refused.
- Slot A is preferred once it is freed.
- Simultaneous releases are counted.
- A grant and a release that coincide net out.
- A waiting lower-priority request is served one cycle later.

// File: rtl/slot2d_pkg.sv
package slot2d_pkg;
  localparam int DIM_W = 16;
  localparam int CFG_W = 3 * DIM_W;

  typedef struct packed {
    logic [DIM_W-1:0] x;
    logic [DIM_W-1:0] y;
    logic [DIM_W-1:0] w;
  } cfg2d_t;
endpackage

// File: rtl/slot2d_arb.sv
module slot2d_arb #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    idx_o = '0;
    // scan downward so the lowest requester wins
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o    = |req_i;
    onehot_o = any_o ? (N'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/slot2d_pick.sv
module slot2d_pick
  import slot2d_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int CNT_W     = 5,
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  cfg2d_t [NUM_SLOTS-1:0]            slot_cfg_i,
  input  logic   [NUM_SLOTS-1:0][CNT_W-1:0] slot_cnt_i,
  input  cfg2d_t                            req_cfg_i,
  output logic                              found_o,
  output logic   [SEL_W-1:0]                sel_o
);
  logic [NUM_SLOTS-1:0] elig;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_elig
    assign elig[s] = (slot_cnt_i[s] == '0) || (slot_cfg_i[s] == req_cfg_i);
  end

  always_comb begin
    sel_o = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (elig[s]) sel_o = SEL_W'(s);
    end
    found_o = |elig;
  end
endmodule

// File: rtl/slot2d_slot.sv
module slot2d_slot
  import slot2d_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  cfg2d_t           cfg_i,
  input  logic [CNT_W-1:0] dec_i,
  output cfg2d_t           cfg_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W:0] sum;
  logic [CNT_W:0] dec_ext;
  logic [CNT_W-1:0] cnt_d;

  assign sum     = {1'b0, cnt_o} + {{CNT_W{1'b0}}, wr_i};
  assign dec_ext = {1'b0, dec_i};
  // saturate at zero
  assign cnt_d   = (dec_ext > sum) ? '0 : CNT_W'(sum - dec_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      cnt_o <= '0;
    end else begin
      if (wr_i) cfg_o <= cfg_i;
      cnt_o <= cnt_d;
    end
  end
endmodule

// File: rtl/slot2d_alloc.sv
module slot2d_alloc
  import slot2d_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_SLOTS = 2,
  localparam int CNT_W    = $clog2(NUM_CH + 1),
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0]             req_i,
  input  logic [NUM_CH*CFG_W-1:0]       req_cfg_i,
  input  logic [NUM_CH-1:0]             cyclic_i,
  input  logic [NUM_CH-1:0]             rel_i,
  output logic [NUM_CH-1:0]             gnt_o,
  output logic [NUM_CH-1:0]             busy_o,
  output logic [SEL_W-1:0]              gnt_sel_o,
  output logic [NUM_CH-1:0]             ch_en_o,
  output logic [NUM_CH*SEL_W-1:0]       ch_slot_o,
  output logic [NUM_SLOTS*CFG_W-1:0]    slot_cfg_o,
  output logic [NUM_SLOTS*CNT_W-1:0]    slot_cnt_o
);
  logic [NUM_CH-1:0]                  elig_req;
  logic                               win_any;
  logic [IDX_W-1:0]                   win_idx;
  logic [NUM_CH-1:0]                  win_oh;
  cfg2d_t                             win_cfg;
  logic                               blocked;
  logic                               found;
  logic [SEL_W-1:0]                   slot_sel;
  logic                               do_gnt;
  logic                               do_busy;
  logic [NUM_CH-1:0]                  rel_v;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]    dec;
  logic [NUM_SLOTS-1:0]               slot_wr;
  cfg2d_t [NUM_SLOTS-1:0]             slot_cfg_q;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]    slot_cnt_q;
  logic [NUM_CH-1:0][SEL_W-1:0]       ch_slot_q;
  logic [NUM_CH-1:0]                  ch_en_q;
  logic [NUM_CH-1:0]                  gnt_q;
  logic [NUM_CH-1:0]                  busy_q;
  logic [SEL_W-1:0]                   sel_q;

  // a channel answered last cycle sits out one cycle
  assign elig_req = req_i & ~(gnt_q | busy_q);

  slot2d_arb #(.N(NUM_CH)) u_arb (
    .req_i    (elig_req),
    .any_o    (win_any),
    .idx_o    (win_idx),
    .onehot_o (win_oh)
  );

  assign win_cfg = req_cfg_i[int'(win_idx)*CFG_W +: CFG_W];
  assign blocked = cyclic_i[win_idx] | ch_en_q[win_idx];

  slot2d_pick #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_pick (
    .slot_cfg_i (slot_cfg_q),
    .slot_cnt_i (slot_cnt_q),
    .req_cfg_i  (win_cfg),
    .found_o    (found),
    .sel_o      (slot_sel)
  );

  assign do_gnt  = win_any & ~blocked & found;
  assign do_busy = win_any & ~do_gnt;
  assign rel_v   = rel_i & ch_en_q;

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      dec[s] = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (rel_v[c] && ch_slot_q[c] == SEL_W'(s)) dec[s] = dec[s] + CNT_W'(1);
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_wr[s] = do_gnt && (slot_sel == SEL_W'(s));
    slot2d_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (slot_wr[s]),
      .cfg_i  (win_cfg),
      .dec_i  (dec[s]),
      .cfg_o  (slot_cfg_q[s]),
      .cnt_o  (slot_cnt_q[s])
    );
    assign slot_cfg_o[s*CFG_W +: CFG_W] = slot_cfg_q[s];
    assign slot_cnt_o[s*CNT_W +: CNT_W] = slot_cnt_q[s];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_en_q[c]   <= 1'b0;
        ch_slot_q[c] <= '0;
      end else if (do_gnt && win_oh[c]) begin
        ch_en_q[c]   <= 1'b1;
        ch_slot_q[c] <= slot_sel;
      end else if (rel_v[c]) begin
        ch_en_q[c]   <= 1'b0;
      end
    end
    assign ch_slot_o[c*SEL_W +: SEL_W] = ch_slot_q[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      busy_q <= '0;
      sel_q  <= '0;
    end else begin
      gnt_q  <= do_gnt  ? win_oh : '0;
      busy_q <= do_busy ? win_oh : '0;
      if (do_gnt) sel_q <= slot_sel;
    end
  end

  assign gnt_o     = gnt_q;
  assign busy_o    = busy_q;
  assign gnt_sel_o = sel_q;
  assign ch_en_o   = ch_en_q;
endmodule

// File: rtl/slot2d_alloc_chk.sv
module slot2d_alloc_chk
  import slot2d_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_SLOTS = 2,
  localparam int CNT_W    = $clog2(NUM_CH + 1),
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_CH-1:0]          req_i,
  input logic [NUM_CH-1:0]          cyclic_i,
  input logic [NUM_CH-1:0]          rel_i,
  input logic [NUM_CH-1:0]          gnt_o,
  input logic [NUM_CH-1:0]          busy_o,
  input logic [SEL_W-1:0]           gnt_sel_o,
  input logic [NUM_CH-1:0]          ch_en_o,
  input logic [NUM_CH*SEL_W-1:0]    ch_slot_o,
  input logic [NUM_SLOTS*CFG_W-1:0] slot_cfg_o,
  input logic [NUM_SLOTS*CNT_W-1:0] slot_cnt_o
);
  int cnt_total;
  always_comb begin
    cnt_total = 0;
    for (int s = 0; s < NUM_SLOTS; s++) cnt_total = cnt_total + int'(slot_cnt_o[s*CNT_W +: CNT_W]);
  end

  AST_ONE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o | busy_o)); // R10

  AST_RESP_TO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(gnt_o | busy_o) |-> ((gnt_o | busy_o) & ~$past(req_i)) == '0); // R10

  AST_NO_CYCLIC_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |gnt_o |-> (gnt_o & $past(cyclic_i)) == '0); // R8

  AST_BUSY_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|busy_o && $past(rel_i) == '0) |-> (slot_cnt_o == $past(slot_cnt_o) && slot_cfg_o == $past(slot_cfg_o))); // R4

  AST_CNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_total == $countones(ch_en_o)); // R7

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_GNT_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[c] |-> (ch_en_o[c] && ch_slot_o[c*SEL_W +: SEL_W] == gnt_sel_o)); // R5
  end
endmodule

bind slot2d_alloc slot2d_alloc_chk #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .cyclic_i   (cyclic_i),
  .rel_i      (rel_i),
  .gnt_o      (gnt_o),
  .busy_o     (busy_o),
  .gnt_sel_o  (gnt_sel_o),
  .ch_en_o    (ch_en_o),
  .ch_slot_o  (ch_slot_o),
  .slot_cfg_o (slot_cfg_o),
  .slot_cnt_o (slot_cnt_o)
);

// File: tb/slot2d_alloc_bench.sv
module slot2d_alloc_bench;
  localparam int NCH = 16;
  localparam int NS  = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  req = '0;
  logic [NCH*48-1:0] req_cfg = '0;
  logic [NCH-1:0]  cyc = '0;
  logic [NCH-1:0]  rel = '0;
  logic [NCH-1:0]  gnt, busy;
  logic            gsel;
  logic [NCH-1:0]  ch_en;
  logic [NCH-1:0]  ch_slot;
  logic [NS*48-1:0] scfg;
  logic [NS*5-1:0]  scnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  slot2d_alloc u_slot2d_alloc (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .req_cfg_i (req_cfg),
    .cyclic_i (cyc), .rel_i (rel), .gnt_o (gnt), .busy_o (busy),
    .gnt_sel_o (gsel), .ch_en_o (ch_en), .ch_slot_o (ch_slot),
    .slot_cfg_o (scfg), .slot_cnt_o (scnt)
  );

  typedef struct packed {
    logic [3:0]  ch;
    logic [15:0] x;
    logic [15:0] y;
    logic [15:0] w;
    logic        cyc;
    logic        exp_gnt;
    logic        exp_sel;
    logic [4:0]  cnt_a;
    logic [4:0]  cnt_b;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 16'd10, 16'd4, 16'd12, 1'b0, 1'b1, 1'b0, 5'd1, 5'd0}, // R2 free A
    '{4'd1, 16'd10, 16'd4, 16'd12, 1'b0, 1'b1, 1'b0, 5'd2, 5'd0}, // R2 share A
    '{4'd2, 16'd20, 16'd5, 16'd24, 1'b0, 1'b1, 1'b1, 5'd2, 5'd1}, // R2 free B
    '{4'd3, 16'd30, 16'd1, 16'd30, 1'b0, 1'b0, 1'b0, 5'd2, 5'd1}, // R4 none
    '{4'd4, 16'd20, 16'd5, 16'd24, 1'b0, 1'b1, 1'b1, 5'd2, 5'd2}, // R2 share B
    '{4'd5, 16'd20, 16'd5, 16'd25, 1'b0, 1'b0, 1'b0, 5'd2, 5'd2}, // R4 stride differs
    '{4'd6, 16'd10, 16'd4, 16'd12, 1'b1, 1'b0, 1'b0, 5'd2, 5'd2}, // R8 cyclic
    '{4'd0, 16'd10, 16'd4, 16'd12, 1'b0, 1'b0, 1'b0, 5'd2, 5'd2}  // R9 already holds
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] cnt_of(input int s);
    return scnt[s*5 +: 5];
  endfunction

  task automatic set_cfg(input int ch, input logic [15:0] x, y, w);
    req_cfg[ch*48 +: 48] = {x, y, w};
  endtask

  task automatic pulse_rel(input logic [NCH-1:0] m);
    @(negedge clk); rel = m;
    @(negedge clk); rel = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cnt", 64'(scnt), 64'd0);
    chk("R1 en", 64'(ch_en), 64'd0);
    chk("R1 resp", 64'(gnt | busy), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      set_cfg(int'(VEC[i].ch), VEC[i].x, VEC[i].y, VEC[i].w);
      cyc[VEC[i].ch] = VEC[i].cyc;
      req[VEC[i].ch] = 1'b1;
      @(negedge clk);
      req = '0;
      chk($sformatf("R2/R4 vec%0d gnt", i), 64'(gnt), VEC[i].exp_gnt ? 64'(1) << VEC[i].ch : 64'd0);
      chk($sformatf("R4/R8/R9 vec%0d busy", i), 64'(busy), VEC[i].exp_gnt ? 64'd0 : 64'(1) << VEC[i].ch);
      if (VEC[i].exp_gnt) begin
        chk($sformatf("R2 vec%0d sel", i), 64'(gsel), 64'(VEC[i].exp_sel));
        chk($sformatf("R5 vec%0d slot", i), 64'(ch_slot[VEC[i].ch]), 64'(VEC[i].exp_sel));
        chk($sformatf("R3 vec%0d cfg", i), 64'(scfg[int'(VEC[i].exp_sel)*48 +: 48]),
            64'({VEC[i].x, VEC[i].y, VEC[i].w}));
      end
      chk($sformatf("R3 vec%0d cnt A", i), 64'(cnt_of(0)), 64'(VEC[i].cnt_a));
      chk($sformatf("R3 vec%0d cnt B", i), 64'(cnt_of(1)), 64'(VEC[i].cnt_b));
      cyc = '0;
      @(negedge clk);
    end
    chk("R5 en after table", 64'(ch_en), 64'h0017);

    // R6 single release
    pulse_rel(16'h0002);
    chk("R6 cnt A", 64'(cnt_of(0)), 64'd1);
    chk("R6 flag", 64'(ch_en[1]), 64'd0);
    // R7 release without flag ignored
    pulse_rel(16'h0002);
    chk("R7 cnt A", 64'(cnt_of(0)), 64'd1);
    chk("R7 cnt B", 64'(cnt_of(1)), 64'd2);
    // R6 simultaneous release of B
    pulse_rel(16'h0014);
    chk("R6 dual cnt B", 64'(cnt_of(1)), 64'd0);
    pulse_rel(16'h0001);
    chk("R7 cnt A zero", 64'(cnt_of(0)), 64'd0);
    pulse_rel(16'h0001);
    chk("R7 no underflow", 64'(cnt_of(0)), 64'd0);

    // R2 freed A preferred, overwritten
    set_cfg(3, 16'd30, 16'd1, 16'd30);
    req[3] = 1'b1;
    @(negedge clk); req = '0;
    chk("R2 A reused", 64'(gsel), 64'd0);
    chk("R3 A cfg", 64'(scfg[47:0]), 64'({16'd30, 16'd1, 16'd30}));
    @(negedge clk);

    // R10 priority: ch7 and ch9 together
    set_cfg(7, 16'd40, 16'd2, 16'd40);
    set_cfg(9, 16'd50, 16'd3, 16'd50);
    req[7] = 1'b1; req[9] = 1'b1;
    @(negedge clk); req[7] = 1'b0;
    chk("R10 first gnt", 64'(gnt), 64'h0080);
    chk("R10 first busy", 64'(busy), 64'd0);
    @(negedge clk); req[9] = 1'b0;
    chk("R10 second busy", 64'(busy), 64'h0200);
    chk("R10 second gnt", 64'(gnt), 64'd0);
    @(negedge clk);

    // R11 grant and release on A in the same cycle
    set_cfg(10, 16'd30, 16'd1, 16'd30);
    req[10] = 1'b1; rel[3] = 1'b1;
    @(negedge clk); req = '0; rel = '0;
    chk("R11 gnt", 64'(gnt), 64'h0400);
    chk("R11 cnt A", 64'(cnt_of(0)), 64'd1);
    chk("R11 flags", 64'({ch_en[10], ch_en[3]}), 64'b10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule